// File: doc/BRIEF.md
# Serial Bus Block Transfer Controller

This block turns one block-read or block-write request into the sequence of byte-level commands that a two-wire serial bus master needs. It sits above a byte engine. That engine runs one command at a time: START followed by a byte write, a plain byte write, a byte read that answers with ACK, a byte read that answers with NACK and then issues STOP, or a lone STOP. The engine reports back whether a write was acknowledged and which byte a read returned. Write data comes into the block on a simple byte stream. Read data leaves it on another byte stream.

There are two addressing styles. In normal mode the block sends a 7-bit device address, then a one-byte register offset, and for reads it follows these with a repeated START. In legacy mode the device takes the offset itself as its address byte, so no offset byte is sent. Writes go out in chunks of at most `CHUNK` bytes. After each chunk the block polls the device with an addressed read until the device acknowledges, and then reads one byte and drops it. When the transfer ends, a one-cycle `done` pulse is raised, and `done_fail` is set on that pulse if the transfer failed.

Top module: `twi_block_xfer`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `cmd_valid` are 0. Exactly one command is outstanding at a time.
- R2: In legacy mode every address phase is a single START+write (`cmd_op`=0) of `{offset[6:0], rw}`, with rw=1 for read and 0 for write, and no offset byte. Command codes: 0 START+write, 1 write, 2 read+ACK, 3 read+NACK+STOP, 4 STOP. For codes 2 to 4, `cmd_byte` is 0.
- R3: A normal-mode read sends START+write `{dev,0}`, then write `offset`, then stays idle for `GAP_CYCLES` cycles, then sends START+write `{dev,1}`. There is no STOP anywhere in that sequence. The repeated START is issued exactly `GAP_CYCLES`+1 cycles after the engine completes the offset byte.
- R4: In a read, a NACK on the first address byte or on the repeated START is followed by a STOP and a failure. A NACK on the offset byte fails the transfer with no further command.
- R5: A read of N bytes issues N-1 read+ACK commands and then one read+NACK+STOP. Each byte returned by the engine appears on `rd_data` with `rd_valid` for one cycle, in order.
- R6: A write sends at most `CHUNK` data bytes per chunk, taken in order from the write stream. Each chunk repeats the address phase using the start offset plus the number of bytes already written, and ends with a STOP.
- R7: After each chunk STOP the block sends START+write `{dev,1}` repeatedly, with a STOP after every NACK. After `POLL_MAX` NACKs in a row the write fails.
- R8: Once a poll is acknowledged, the block issues one read+NACK+STOP. The byte it returns never appears on the read stream.
- R9: In a write, a NACK on the address, the offset or any data byte is followed by a STOP and a failure.
- R10: `done` is high for exactly one cycle per accepted request. `done_fail` is 0 on success and 1 on failure.
- R11: A request with length 0 completes successfully and issues no command. `req_start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Request strobe, accepted only while idle |
| req_write | input | 1 | 1 for block write, 0 for block read |
| req_legacy | input | 1 | 1 selects offset-as-address mode |
| req_dev | input | 7 | Device address |
| req_offset | input | 8 | Start register offset |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_fail | output | 1 | Failure status, valid with done |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Write stream byte taken this cycle |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| cmd_valid | output | 1 | Command strobe to the byte engine |
| cmd_op | output | 3 | Command code (see R2) |
| cmd_byte | output | 8 | Byte to write |
| eng_done | input | 1 | Engine finished the command |
| eng_ack | input | 1 | Write was acknowledged |
| eng_rdata | input | 8 | Byte returned by a read |

## Verification
The bench builds the block with `CHUNK`=4, `POLL_MAX`=3, `GAP_CYCLES`=8 and an 8-bit length. With these values, poll exhaustion is reached after three refusals, the repeated-START spacing can be measured exactly, and a 9-byte write crosses two chunk boundaries. At this size every command position of a read and of a multi-chunk write can be refused one at a time, in both address modes. The resulting command log and read stream are compared with a command-level model written from the requirements.

// File: rtl/twi_xfer_pkg.sv
package twi_xfer_pkg;

  typedef enum logic [2:0] {
    OP_START_WR = 3'd0,
    OP_WR       = 3'd1,
    OP_RD_ACK   = 3'd2,
    OP_RD_LAST  = 3'd3,
    OP_STOP     = 3'd4
  } xfer_op_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_OFFS, S_GAP, S_RSTART, S_RDATA, S_WDATA,
    S_WSTOP, S_POLL, S_PSTOP, S_DUMMY, S_FSTOP, S_DONE
  } xfer_st_t;

  // first byte of an address phase
  function automatic logic [7:0] lead_byte(input logic legacy, input logic [6:0] dev,
                                           input logic [7:0] off, input logic rd);
    return legacy ? {off[6:0], rd} : {dev, rd};
  endfunction

  // true when the byte just written closes the current chunk
  function automatic logic chunk_closes(input int unsigned left_in_chunk,
                                        input int unsigned left_total);
    return (left_in_chunk == 1) || (left_total == 1);
  endfunction

endpackage

// File: rtl/twi_gap_timer.sv
module twi_gap_timer #(
  parameter int GAP_CYCLES = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic fire
);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  logic [GAP_W-1:0] cnt;

  assign fire = run && (cnt == GAP_W'(GAP_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!fire)  cnt <= cnt + GAP_W'(1);
  end

  assert_gap_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= GAP_W'(GAP_CYCLES - 1));

endmodule

// File: rtl/twi_poll_limit.sv
module twi_poll_limit #(
  parameter int POLL_MAX = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last_try
);
  localparam int PL_W = $clog2(POLL_MAX + 1);

  logic [PL_W-1:0] cnt;

  assign last_try = (cnt == PL_W'(POLL_MAX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + PL_W'(1);
  end

  assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < PL_W'(POLL_MAX));

endmodule

// File: rtl/twi_block_xfer.sv
module twi_block_xfer
  import twi_xfer_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int CHUNK      = 4,
  parameter int POLL_MAX   = 100,
  parameter int GAP_CYCLES = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic             req_write,
  input  logic             req_legacy,
  input  logic [6:0]       req_dev,
  input  logic [7:0]       req_offset,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             done_fail,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  input  logic             eng_done,
  input  logic             eng_ack,
  input  logic [7:0]       eng_rdata
);
  localparam int CH_W = $clog2(CHUNK + 1);

  xfer_st_t         st;
  xfer_op_t         op_w;
  logic             issued, want, step;
  logic             is_wr, is_leg, fail_q;
  logic [6:0]       dev_q;
  logic [7:0]       off_q;
  logic [LEN_W-1:0] rem_q;
  logic [CH_W-1:0]  chunk_q;
  logic             gap_fire, poll_last, poll_clear, poll_bump, accept;

  assign step       = issued && eng_done;
  assign accept     = (st == S_IDLE) && req_start;
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_DONE);
  assign done_fail  = fail_q;
  assign poll_clear = (st == S_WSTOP) && step;
  assign poll_bump  = (st == S_PSTOP) && step && !poll_last;

  twi_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(st == S_GAP), .fire(gap_fire));

  twi_poll_limit #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_n), .clear(poll_clear), .bump(poll_bump),
    .last_try(poll_last));

  always_comb begin
    op_w     = OP_STOP;
    cmd_byte = 8'h00;
    want     = 1'b0;
    case (st)
      S_ADDR: begin
        want = 1'b1; op_w = OP_START_WR;
        cmd_byte = lead_byte(is_leg, dev_q, off_q, is_leg && !is_wr);
      end
      S_OFFS:   begin want = 1'b1; op_w = OP_WR; cmd_byte = off_q; end
      S_RSTART, S_POLL: begin
        want = 1'b1; op_w = OP_START_WR; cmd_byte = {dev_q, 1'b1};
      end
      S_RDATA:  begin want = 1'b1; op_w = (rem_q == LEN_W'(1)) ? OP_RD_LAST : OP_RD_ACK; end
      S_WDATA:  begin want = wr_valid; op_w = OP_WR; cmd_byte = wr_data; end
      S_WSTOP, S_PSTOP, S_FSTOP: want = 1'b1;
      S_DUMMY:  begin want = 1'b1; op_w = OP_RD_LAST; end
      default:  ;
    endcase
  end

  assign cmd_valid = want && !issued;
  assign cmd_op    = op_w;
  assign wr_ready  = (st == S_WDATA) && cmd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; issued <= 1'b0; is_wr <= 1'b0; is_leg <= 1'b0;
      fail_q <= 1'b0; dev_q <= '0; off_q <= '0; rem_q <= '0; chunk_q <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (cmd_valid)  issued <= 1'b1;
      else if (step)  issued <= 1'b0;
      if (accept) begin
        is_wr <= req_write; is_leg <= req_legacy; dev_q <= req_dev;
        off_q <= req_offset; rem_q <= req_len; chunk_q <= CH_W'(CHUNK);
        fail_q <= 1'b0;
        st <= (req_len == '0) ? S_DONE : S_ADDR;
      end else if (st == S_GAP) begin
        if (gap_fire) st <= S_RSTART;
      end else if (st == S_DONE) begin
        st <= S_IDLE;
      end else if (step) begin
        case (st)
          S_ADDR:   st <= !eng_ack ? S_FSTOP : (!is_leg ? S_OFFS : (is_wr ? S_WDATA : S_RDATA));
          S_OFFS:   if (!eng_ack) begin
                      if (is_wr) st <= S_FSTOP;
                      else begin fail_q <= 1'b1; st <= S_DONE; end
                    end else st <= is_wr ? S_WDATA : S_GAP;
          S_RSTART: st <= eng_ack ? S_RDATA : S_FSTOP;
          S_RDATA: begin
            rd_valid <= 1'b1; rd_data <= eng_rdata;
            rem_q <= rem_q - LEN_W'(1);
            if (rem_q == LEN_W'(1)) st <= S_DONE;
          end
          S_WDATA:
            if (!eng_ack) st <= S_FSTOP;
            else begin
              rem_q   <= rem_q - LEN_W'(1);
              off_q   <= off_q + 8'd1;
              chunk_q <= chunk_q - CH_W'(1);
              if (chunk_closes(int'(chunk_q), int'(rem_q))) st <= S_WSTOP;
            end
          S_WSTOP:  st <= S_POLL;
          S_POLL:   st <= eng_ack ? S_DUMMY : S_PSTOP;
          S_PSTOP:  if (poll_last) begin fail_q <= 1'b1; st <= S_DONE; end
                    else st <= S_POLL;
          S_DUMMY:  if (rem_q == '0) st <= S_DONE;
                    else begin chunk_q <= CH_W'(CHUNK); st <= S_ADDR; end
          S_FSTOP:  begin fail_q <= 1'b1; st <= S_DONE; end
          default:  st <= S_IDLE;
        endcase
      end
    end
  end

  assert_single_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_gap_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_fire |=> (cmd_valid && cmd_op == 3'd0 && cmd_byte[0]));

  assert_offs_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFFS && step && !eng_ack && !is_wr) |=> (done && done_fail));

  assert_rd_only_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !is_wr);

  assert_dummy_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DUMMY && step) |=> !rd_valid);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

endmodule

// File: tb/sim_twi_block_xfer.sv
module sim_twi_block_xfer;
  localparam int LEN_W = 8, CHUNK = 4, PMAX = 3, GAP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_start = 0, req_write = 0, req_legacy = 0;
  logic [6:0] req_dev = 0;
  logic [7:0] req_offset = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic busy, done, done_fail, wr_ready, rd_valid, cmd_valid;
  logic [7:0] wr_data, rd_data, cmd_byte;
  logic [2:0] cmd_op;
  logic eng_done = 0, eng_ack = 0;
  logic [7:0] eng_rdata = 0;

  logic [7:0] wbuf [0:63];
  int wptr = 0;
  assign wr_data = wbuf[wptr];

  twi_block_xfer #(.LEN_W(LEN_W), .CHUNK(CHUNK), .POLL_MAX(PMAX), .GAP_CYCLES(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_legacy(req_legacy), .req_dev(req_dev), .req_offset(req_offset), .req_len(req_len),
    .busy(busy), .done(done), .done_fail(done_fail), .wr_data(wr_data), .wr_valid(1'b1),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .eng_done(eng_done), .eng_ack(eng_ack),
    .eng_rdata(eng_rdata));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int log_op [0:255]; int log_b [0:255]; int log_iss [0:255]; int log_dn [0:255];
  int exp_op [0:255]; int exp_b [0:255];
  int log_n = 0, exp_n = 0;
  int rd_got [0:63]; int rd_exp [0:63]; int rd_n = 0, rdx_n = 0;
  int done_seen = 0, fail_seen = 0;
  bit cur_write = 0; int nack_at = -1, poll_nacks = 0;
  int e_polls = 0, m_polls = 0, pend = 0, cur_idx = 0;
  bit pend_ack = 0;

  function automatic int pat(input int idx);
    return ((idx * 37 + 11) & 255) ^ 8'h5C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial forever @(posedge clk) cyc++;

  // command-level byte engine and slave
  initial forever begin
    @(negedge clk);
    eng_done = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        eng_done = 1; eng_ack = pend_ack; eng_rdata = 8'(pat(cur_idx));
        log_dn[cur_idx] = cyc;
      end
    end
    if (cmd_valid) begin
      cur_idx = log_n;
      log_op[log_n] = int'(cmd_op); log_b[log_n] = int'(cmd_byte); log_iss[log_n] = cyc;
      if (cmd_op == 3'd1) e_polls = 0;
      pend_ack = (log_n != nack_at);
      if (cur_write && cmd_op == 3'd0 && cmd_byte[0] && e_polls < poll_nacks) begin
        pend_ack = 0; e_polls++;
      end
      log_n++; pend = 2;
      if (wr_ready) wptr++;
    end
    if (rd_valid) begin rd_got[rd_n] = int'(rd_data); rd_n++; end
    if (done) begin done_seen++; fail_seen = int'(done_fail); end
  end

  task automatic emit(input int op, input int b, output bit a);
    exp_op[exp_n] = op; exp_b[exp_n] = b;
    if (op == 1) m_polls = 0;
    a = (exp_n != nack_at);
    if (cur_write && op == 0 && b[0] && m_polls < poll_nacks) begin a = 0; m_polls++; end
    if (!cur_write && (op == 2 || op == 3)) begin rd_exp[rdx_n] = pat(exp_n); rdx_n++; end
    exp_n++;
  endtask

  task automatic model(input bit leg, input int dev, input int off, input int len, output bit f);
    bit a; int o, rem, n, p, polls;
    f = 0; exp_n = 0; rdx_n = 0; m_polls = 0;
    if (len == 0) return;
    if (!cur_write) begin
      emit(0, leg ? (((off & 127) << 1) | 1) : (dev << 1), a);
      if (!a) begin emit(4, 0, a); f = 1; return; end
      if (!leg) begin
        emit(1, off, a);
        if (!a) begin f = 1; return; end
        emit(0, (dev << 1) | 1, a);
        if (!a) begin emit(4, 0, a); f = 1; return; end
      end
      for (int i = 0; i < len; i++) emit((i == len - 1) ? 3 : 2, 0, a);
      return;
    end
    o = off; rem = len; p = 0;
    while (rem > 0) begin
      emit(0, leg ? ((o & 127) << 1) : (dev << 1), a);
      if (!a) begin emit(4, 0, a); f = 1; return; end
      if (!leg) begin
        emit(1, o & 255, a);
        if (!a) begin emit(4, 0, a); f = 1; return; end
      end
      n = (rem < CHUNK) ? rem : CHUNK;
      for (int j = 0; j < n; j++) begin
        emit(1, int'(wbuf[p]), a); p++;
        if (!a) begin emit(4, 0, a); f = 1; return; end
      end
      o += n; rem -= n;
      emit(4, 0, a);
      polls = 0;
      forever begin
        emit(0, (dev << 1) | 1, a);
        if (a) break;
        emit(4, 0, a); polls++;
        if (polls == PMAX) begin f = 1; return; end
      end
      emit(3, 0, a);
    end
  endtask

  task automatic run(input bit leg, input bit wr, input int len, input int off,
                     input int nk, input int pn, input string tag, input bit poke);
    bit f; int mism, t, bad_i;
    int dev = 7'h51;
    cur_write = wr; nack_at = nk; poll_nacks = pn;
    for (int i = 0; i < 64; i++) wbuf[i] = 8'((i * 13 + off) ^ 8'h3C);
    model(leg, dev, off, len, f);
    log_n = 0; rd_n = 0; done_seen = 0; wptr = 0; e_polls = 0;
    @(negedge clk);
    req_legacy = leg; req_write = wr; req_dev = 7'(dev); req_offset = 8'(off);
    req_len = LEN_W'(len); req_start = 1;
    @(negedge clk); req_start = 0;
    if (poke) begin
      repeat (5) @(negedge clk);
      req_write = ~wr; req_len = 8'd9; req_offset = 8'hEE; req_start = 1;
      @(negedge clk); req_start = 0;
    end
    t = 0;
    while (done_seen == 0 && t < 4000) begin @(negedge clk); t++; end
    repeat (8) @(negedge clk);
    chk(done_seen == 1, "R10", "done pulses", done_seen, 1);
    chk(fail_seen == int'(f), "R10", "done_fail", fail_seen, int'(f));
    chk(log_n == exp_n, tag, "command count", log_n, exp_n);
    mism = 0; bad_i = 0;
    if (log_n == exp_n)
      for (int i = 0; i < exp_n; i++)
        if (log_op[i] != exp_op[i] || log_b[i] != exp_b[i]) begin
          if (mism == 0) bad_i = i;
          mism++;
        end
    chk(mism == 0, tag, "command op*256+byte at first mismatch",
        log_op[bad_i] * 256 + log_b[bad_i], exp_op[bad_i] * 256 + exp_b[bad_i]);
    chk(rd_n == rdx_n, wr ? "R8" : "R5", "read stream bytes", rd_n, rdx_n);
    if (rd_n == rdx_n)
      for (int i = 0; i < rd_n; i++)
        if (rd_got[i] != rd_exp[i]) chk(0, "R5", "read byte", rd_got[i], rd_exp[i]);
    if (!leg && !wr && log_n > 2 && exp_n > 2)
      chk(log_iss[2] - log_dn[1] == GAP + 1, "R3", "gap cycles", log_iss[2] - log_dn[1], GAP + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lens [6] = '{0, 1, 2, 4, 5, 9};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cmd_valid, "R1", "reset idle", int'(busy) + int'(done) + int'(cmd_valid), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !cmd_valid, "R1", "idle after reset", int'(busy) + int'(cmd_valid), 0);
    // mode x direction x length sweep
    for (int lg = 0; lg < 2; lg++)
      for (int w = 0; w < 2; w++)
        foreach (lens[k])
          run(lg[0], w[0], lens[k], 8'h10 + lens[k] * 3, -1, w ? (lens[k] % 3) : 0,
              lens[k] == 0 ? "R11" : (lg ? "R2" : (w ? "R6" : "R3")), 0);
    // refusal at every command position
    for (int n = 0; n < 7; n++)  run(0, 0, 3, 8'h40, n, 0, "R4", 0);
    for (int n = 0; n < 18; n++) run(0, 1, 6, 8'h7E, n, 0, "R9", 0);
    for (int n = 0; n < 13; n++) run(1, 1, 5, 8'h21, n, 1, "R9", 0);
    for (int n = 0; n < 4; n++)  run(1, 0, 2, 8'h9A, n, 0, "R4", 0);
    // poll exhaustion and its edge
    run(0, 1, 2, 8'h05, -1, PMAX, "R7", 0);
    run(0, 1, 5, 8'h05, -1, PMAX - 1, "R7", 0);
    run(1, 1, 3, 8'h66, -1, PMAX, "R7", 0);
    // request while busy is ignored
    run(0, 0, 2, 8'h33, -1, 0, "R11", 1);
    run(0, 1, 3, 8'h33, -1, 1, "R11", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule